// File: doc/BRIEF.md
# Serial Control Register Slave with Event Interrupt

This block is the control end of a low-speed serial bus on a sensor. An external host drives the serial clock, the data line into the block and an active-low select. It sends a one-byte command, then one or more data bytes. The command can read or write three small registers: the event flags, the interrupt enables and the mode control. Another read command streams out a three-byte motion report. The mode control and enable values go out on ports to the rest of the sensor.

Event pulses from the sensor set sticky flags. When a flag is set and its enable bit is set, an active-low interrupt line is driven. The host then reads the flag register, and that read clears the flags and releases the line.

Motion deltas from the navigation engine are added into saturating X and Y counters. Reading the report returns the counters and clears them.

All pins are sampled by the system clock through synchronisers. The serial clock must therefore run several times slower than the system clock.

Top module: `spictl_top`

## Requirements
- R1: The serial clock idles high. Data-in is sampled on each falling edge, most significant bit first, in 8-bit words. Data-out shows the current bit of the outgoing byte from select assertion onward and moves to the next bit after each falling edge. Data-out is 0 while select is high and during the command byte.
- R2: A command byte has bit 7 = 1, and bit 6 = 1 for a read or 0 for a write. Bits 3:0 give the address: 0 flags, 2 enables, 4 mode, 8 motion report. If the first byte of a transaction has bit 7 = 0, the whole transaction changes nothing and returns zeros.
- R3: The flag register holds click on bit 7, movement on bit 6, transit on bit 5, slice on bit 4 and read-error on bit 3; bits 2:0 read 0. The enable register uses bits 6:2 in that same order. `irq_n` goes low in the clock cycle after an event whose enable bit is set. A masked event still sets its flag but does not drive `irq_n` low.
- R4: Reading the flag register (0xC0) returns the flags and clears them. `irq_n` goes high once the command byte has been received. An event that arrives during the data byte of that read is kept for the next read.
- R5: The mode register is 7 bits and resets to 0000100. Bits 6:3 select the mode and bit 2 is the analog reset. Command 0x84 followed by a byte writes bits 6:0. Command 0xC4 returns the value in the next byte.
- R6: The enable register resets to 0. It is written with 0x82 (bits 6:2 are stored) and read with 0xC2, which returns bits 1:0 and bit 7 as 0.
- R7: If select is raised before the 8th bit of a byte, that byte is dropped and no register changes.
- R8: Command 0xC8 returns three bytes, each clocked out by a dummy byte. Byte 1 is {Y overflow, X overflow, Y sign, X sign, 1, 0, 0, click seen}, byte 2 is X and byte 3 is Y, both two's complement. The counters and flags restart from zero at the command. Any further bytes return 0.
- R9: The X and Y counters saturate at +127 and -128. When a counter saturates, its overflow bit is set until the next report read.
- R10: Writes to the flag, report or unmapped addresses are ignored. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host, idle high |
| spi_mosi | input | 1 | Serial data from host |
| spi_sel_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to host |
| irq_n | output | 1 | Active-low interrupt |
| evt_click | input | 1 | Click event pulse |
| evt_transit | input | 1 | Transit event pulse |
| evt_slice | input | 1 | Slice event pulse |
| evt_rderr | input | 1 | Read-error event pulse |
| mot_valid | input | 1 | Motion delta strobe; a non-zero delta also sets the movement flag |
| mot_dx | input | 8 | Signed X delta |
| mot_dy | input | 8 | Signed Y delta |
| cfg_mode | output | 7 | Mode register contents |
| cfg_irq_en | output | 5 | Enables, click at bit 4 down to read-error at bit 0 |

## Verification
Flags, and with them `irq_n`, change on the clock edge that samples the event pulse. The bench therefore checks `irq_n` at the falling system-clock edge after a one-cycle pulse.

A serial bit reaches the shifter about SYNC_STAGES+1 clocks after its SCK edge. A register write, flag clear or new outgoing byte follows about SYNC_STAGES+2 clocks after the 8th falling SCK edge. The bench uses a 10-clock SCK half period, so each result has settled long before the bench looks at it. It reads data-out just before each falling SCK edge and checks register outputs 20 clocks after select is raised.

The interrupt for the event that arrives during a flag read is injected in the middle of the data byte, well clear of the command-byte edge.

// File: rtl/spictl_pkg.sv
package spictl_pkg;
    localparam int MOT_W   = 8;
    localparam int NUM_EVT = 5;

    localparam logic [3:0] ADDR_FLAGS  = 4'h0;
    localparam logic [3:0] ADDR_IRQEN  = 4'h2;
    localparam logic [3:0] ADDR_MODE   = 4'h4;
    localparam logic [3:0] ADDR_MOTION = 4'h8;

    localparam logic [6:0] MODE_RESET = 7'b0000100;

    // returns {saturated, result}
    function automatic logic [MOT_W:0] sat_add(input logic [MOT_W-1:0] a,
                                               input logic [MOT_W-1:0] b);
        logic [MOT_W:0] s;
        s = {a[MOT_W-1], a} + {b[MOT_W-1], b};
        if (s[MOT_W] != s[MOT_W-1]) begin
            if (s[MOT_W])
                return {1'b1, 1'b1, {(MOT_W-1){1'b0}}};
            return {1'b1, 1'b0, {(MOT_W-1){1'b1}}};
        end
        return {1'b0, s[MOT_W-1:0]};
    endfunction
endpackage

// File: rtl/spictl_shift.sv
module spictl_shift #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       sel_n,
    output logic       sel_act,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic [1:0] done_idx,
    output logic [2:0] bit_idx
);
    localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0] sck_s;
        logic [S-1:0] mosi_s;
        logic [S-1:0] sel_s;
        logic         sck_prev;
        logic [6:0]   shift;
        logic [2:0]   bit_idx;
        logic [1:0]   byte_idx;
        logic         done;
        logic [1:0]   done_idx;
        logic [7:0]   rx;
    } shift_t;

    shift_t q, d;
    logic sck_now, mosi_now, sel_now;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.sck_s  = {q.sck_s[S-2:0], sck};
        d.mosi_s = {q.mosi_s[S-2:0], mosi};
        d.sel_s  = {q.sel_s[S-2:0], sel_n};
        sck_now  = q.sck_s[S-1];
        mosi_now = q.mosi_s[S-1];
        sel_now  = ~q.sel_s[S-1];
        d.sck_prev = sck_now;
        if (!sel_now) begin
            d.bit_idx  = 3'd0;
            d.byte_idx = 2'd0;
        end else if (q.sck_prev && !sck_now) begin
            if (q.bit_idx == 3'd7) begin
                d.rx       = {q.shift, mosi_now};
                d.done     = 1'b1;
                d.done_idx = q.byte_idx;
                d.bit_idx  = 3'd0;
                if (q.byte_idx != 2'd3)
                    d.byte_idx = q.byte_idx + 2'd1;
            end else begin
                d.shift   = {q.shift[5:0], mosi_now};
                d.bit_idx = q.bit_idx + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.sck_s    <= '1;
            q.sel_s    <= '1;
            q.sck_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sel_act   = ~q.sel_s[S-1];
    assign byte_done = q.done;
    assign rx_byte   = q.rx;
    assign done_idx  = q.done_idx;
    assign bit_idx   = q.bit_idx;
endmodule

// File: rtl/spictl_events.sv
module spictl_events
    import spictl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic               clr,
    input  logic [NUM_EVT-1:0] enable,
    output logic [NUM_EVT-1:0] flags,
    output logic               irq_n
);
    typedef struct packed {
        logic [NUM_EVT-1:0] flags;
    } evt_t;

    evt_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < NUM_EVT; i++)
            d.flags[i] = (q.flags[i] & ~clr) | evt_set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flags = q.flags;
    assign irq_n = ~|(q.flags & enable);
endmodule

// File: rtl/spictl_motion.sv
module spictl_motion
    import spictl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mv_valid,
    input  logic [MOT_W-1:0] dx,
    input  logic [MOT_W-1:0] dy,
    input  logic             click,
    input  logic             clr,
    output logic [7:0]       rpt0,
    output logic [MOT_W-1:0] rpt_x,
    output logic [MOT_W-1:0] rpt_y,
    output logic             moved
);
    typedef struct packed {
        logic [MOT_W-1:0] ax;
        logic [MOT_W-1:0] ay;
        logic             ovx;
        logic             ovy;
        logic             clk_seen;
    } mot_t;

    mot_t q, d;
    logic [MOT_W:0] sx, sy;

    always_comb begin
        d  = clr ? '0 : q;
        sx = sat_add(d.ax, dx);
        sy = sat_add(d.ay, dy);
        if (mv_valid) begin
            d.ax  = sx[MOT_W-1:0];
            d.ay  = sy[MOT_W-1:0];
            d.ovx = d.ovx | sx[MOT_W];
            d.ovy = d.ovy | sy[MOT_W];
        end
        if (click)
            d.clk_seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign moved = mv_valid & ((dx != '0) | (dy != '0));
    assign rpt0  = {q.ovy, q.ovx, q.ay[MOT_W-1], q.ax[MOT_W-1], 1'b1, 2'b00, q.clk_seen};
    assign rpt_x = q.ax;
    assign rpt_y = q.ay;
endmodule

// File: rtl/spictl_top.sv
module spictl_top
    import spictl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic             spi_sel_n,
    output logic             spi_miso,
    output logic             irq_n,
    input  logic             evt_click,
    input  logic             evt_transit,
    input  logic             evt_slice,
    input  logic             evt_rderr,
    input  logic             mot_valid,
    input  logic [MOT_W-1:0] mot_dx,
    input  logic [MOT_W-1:0] mot_dy,
    output logic [6:0]       cfg_mode,
    output logic [4:0]       cfg_irq_en
);
    logic             sel_act, fe_done;
    logic [7:0]       fe_rx;
    logic [1:0]       fe_idx;
    logic [2:0]       fe_bit;
    logic [NUM_EVT-1:0] flags, evt_vec;
    logic             clr_flags, clr_motion, moved;
    logic [7:0]       rpt0;
    logic [MOT_W-1:0] rpt_x, rpt_y;

    typedef struct packed {
        logic       cmd_ok;
        logic       cmd_rd;
        logic [3:0] cmd_addr;
        logic [7:0] tx;
        logic [6:0] mode;
        logic [4:0] en;
        logic [7:0] rep1;
        logic [7:0] rep2;
    } ctl_t;

    ctl_t q, d;

    spictl_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .sel_n(spi_sel_n),
        .sel_act(sel_act), .byte_done(fe_done), .rx_byte(fe_rx),
        .done_idx(fe_idx), .bit_idx(fe_bit)
    );

    assign evt_vec = {evt_click, moved, evt_transit, evt_slice, evt_rderr};

    spictl_events u_events (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_vec), .clr(clr_flags),
        .enable(q.en), .flags(flags), .irq_n(irq_n)
    );

    spictl_motion u_motion (
        .clk(clk), .rst_n(rst_n), .mv_valid(mot_valid), .dx(mot_dx), .dy(mot_dy),
        .click(evt_click), .clr(clr_motion), .rpt0(rpt0), .rpt_x(rpt_x),
        .rpt_y(rpt_y), .moved(moved)
    );

    always_comb begin
        d          = q;
        clr_flags  = 1'b0;
        clr_motion = 1'b0;
        if (!sel_act) begin
            d.tx     = 8'h00;
            d.cmd_ok = 1'b0;
        end else if (fe_done) begin
            d.tx = 8'h00;
            if (fe_idx == 2'd0) begin
                d.cmd_ok   = fe_rx[7];
                d.cmd_rd   = fe_rx[6];
                d.cmd_addr = fe_rx[3:0];
                if (fe_rx[7] && fe_rx[6]) begin
                    case (fe_rx[3:0])
                        ADDR_FLAGS: begin
                            d.tx      = {flags, 3'b000};
                            clr_flags = 1'b1;
                        end
                        ADDR_IRQEN: d.tx = {1'b0, q.en, 2'b00};
                        ADDR_MODE:  d.tx = {1'b0, q.mode};
                        ADDR_MOTION: begin
                            d.tx       = rpt0;
                            d.rep1     = rpt_x;
                            d.rep2     = rpt_y;
                            clr_motion = 1'b1;
                        end
                        default: d.tx = 8'h00;
                    endcase
                end
            end else if (q.cmd_ok) begin
                if (!q.cmd_rd && fe_idx == 2'd1) begin
                    case (q.cmd_addr)
                        ADDR_IRQEN: d.en   = fe_rx[6:2];
                        ADDR_MODE:  d.mode = fe_rx[6:0];
                        default: ;
                    endcase
                end
                if (q.cmd_rd && q.cmd_addr == ADDR_MOTION) begin
                    if (fe_idx == 2'd1)      d.tx = q.rep1;
                    else if (fe_idx == 2'd2) d.tx = q.rep2;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= MODE_RESET;
        end else begin
            q <= d;
        end
    end

    assign spi_miso   = sel_act & q.tx[3'd7 - fe_bit];
    assign cfg_mode   = q.mode;
    assign cfg_irq_en = q.en;
endmodule

// File: rtl/spictl_checker.sv
module spictl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_act,
    input logic       fe_done,
    input logic [1:0] fe_idx,
    input logic [7:0] fe_rx,
    input logic       spi_miso,
    input logic       irq_n,
    input logic       evt_click,
    input logic       evt_transit,
    input logic       evt_slice,
    input logic       evt_rderr,
    input logic       mot_valid,
    input logic [6:0] cfg_mode,
    input logic [4:0] cfg_irq_en
);
    logic no_evt;
    assign no_evt = !(evt_click || evt_transit || evt_slice || evt_rderr || mot_valid);

    AST_MISO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |-> !spi_miso); // R1

    AST_ENABLED_CLICK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_click && cfg_irq_en[4]) |=> !irq_n); // R3

    AST_NO_IRQ_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_en == 5'd0) |-> irq_n); // R3

    AST_FLAG_READ_RELEASES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_act && fe_done && fe_idx == 2'd0 && fe_rx == 8'hC0 && no_evt) |=> irq_n); // R4

    AST_MODE_CHANGES_ON_WHOLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_mode) |-> $past(fe_done)); // R7

    AST_ENABLE_CHANGES_ON_WHOLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_irq_en) |-> $past(fe_done)); // R6
endmodule

bind spictl_top spictl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .fe_done(fe_done),
    .fe_idx(fe_idx), .fe_rx(fe_rx), .spi_miso(spi_miso), .irq_n(irq_n),
    .evt_click(evt_click), .evt_transit(evt_transit), .evt_slice(evt_slice),
    .evt_rderr(evt_rderr), .mot_valid(mot_valid), .cfg_mode(cfg_mode),
    .cfg_irq_en(cfg_irq_en)
);

// File: tb/spictl_top_test.sv
module spictl_top_test;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b1, mosi = 1'b0, sel_n = 1'b1;
    logic miso, irq_n;
    logic e_click = 0, e_transit = 0, e_slice = 0, e_rderr = 0;
    logic m_valid = 0;
    logic [7:0] m_dx = 0, m_dy = 0;
    logic [6:0] cfg_mode;
    logic [4:0] cfg_irq_en;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spictl_top uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_sel_n(sel_n),
        .spi_miso(miso), .irq_n(irq_n), .evt_click(e_click), .evt_transit(e_transit),
        .evt_slice(e_slice), .evt_rderr(e_rderr), .mot_valid(m_valid), .mot_dx(m_dx),
        .mot_dy(m_dy), .cfg_mode(cfg_mode), .cfg_irq_en(cfg_irq_en)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b0;
            wait_clk(HALF);
            sck = 1'b1;
        end
    endtask

    // n bytes, first byte in bits 39:32
    task automatic spi_xfer(input int n, input logic [39:0] txv, output logic [39:0] rxv);
        logic [7:0] r;
        rxv = '0;
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) begin
            spi_byte(txv[39-8*k -: 8], r);
            rxv[39-8*k -: 8] = r;
        end
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] val);
        logic [39:0] r;
        spi_xfer(2, {cmd, val, 24'h0}, r);
    endtask

    task automatic read_reg(input logic [7:0] cmd, output logic [7:0] val);
        logic [39:0] r;
        spi_xfer(2, {cmd, 32'h0}, r);
        val = r[31:24];
    endtask

    task automatic pulse_motion(input logic [7:0] dx, input logic [7:0] dy);
        @(negedge clk);
        m_valid = 1; m_dx = dx; m_dy = dy;
        @(negedge clk);
        m_valid = 0; m_dx = 0; m_dy = 0;
    endtask

    task automatic t_reset;
        check(irq_n === 1'b1, "R3 reset irq_n", irq_n, 1);
        check(cfg_mode === 7'h04, "R5 reset mode", cfg_mode, 7'h04);
        check(cfg_irq_en === 5'h00, "R6 reset enable", cfg_irq_en, 0);
        check(miso === 1'b0, "R1 miso idle", miso, 0);
    endtask

    task automatic t_mode;
        logic [39:0] r;
        write_reg(8'h84, 8'h30);
        check(cfg_mode === 7'h30, "R5 mode write", cfg_mode, 7'h30);
        spi_xfer(2, {8'hC4, 32'h0}, r);
        check(r[39:32] === 8'h00, "R1 miso zero in command byte", r[39:32], 0);
        check(r[31:24] === 8'h30, "R5 mode readback", r[31:24], 8'h30);
    endtask

    task automatic t_enable;
        logic [7:0] v;
        write_reg(8'h82, 8'hFF);
        check(cfg_irq_en === 5'h1F, "R6 enable write", cfg_irq_en, 5'h1F);
        read_reg(8'hC2, v);
        check(v === 8'h7C, "R6 enable readback", v, 8'h7C);
        write_reg(8'h82, 8'h20); // movement only
        check(cfg_irq_en === 5'h08, "R6 enable movement only", cfg_irq_en, 5'h08);
    endtask

    task automatic t_abort;
        logic [7:0] r;
        sel_n = 1'b0;
        wait_clk(HALF);
        spi_byte(8'h84, r);
        for (int i = 7; i >= 4; i--) begin
            mosi = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
            sck = 1'b1;
        end
        sel_n = 1'b1;
        wait_clk(2 * HALF);
        check(cfg_mode === 7'h30, "R7 aborted write leaves mode", cfg_mode, 7'h30);
        read_reg(8'hC4, r);
        check(r === 8'h30, "R7 mode readback after abort", r, 8'h30);
    endtask

    task automatic t_noncmd;
        logic [39:0] r;
        spi_xfer(2, {8'h44, 8'h7F, 24'h0}, r);
        check(cfg_mode === 7'h30, "R2 non-command byte ignored", cfg_mode, 7'h30);
        check(r[31:24] === 8'h00, "R2 non-command returns zero", r[31:24], 0);
    endtask

    task automatic t_irq;
        logic [39:0] r;
        logic [7:0] v;
        @(negedge clk); e_click = 1; @(negedge clk); e_click = 0;
        check(irq_n === 1'b1, "R3 masked click no irq", irq_n, 1);
        read_reg(8'hC0, v);
        check(v === 8'h80, "R3 click flag set while masked", v, 8'h80);
        pulse_motion(8'h01, 8'h00);
        check(irq_n === 1'b0, "R3 enabled movement drives irq", irq_n, 0);
        fork
            spi_xfer(2, {8'hC0, 32'h0}, r);
            begin
                wait_clk(250);
                @(negedge clk); e_transit = 1; @(negedge clk); e_transit = 0;
            end
        join
        check(r[31:24] === 8'h40, "R4 flag read returns movement", r[31:24], 8'h40);
        check(irq_n === 1'b1, "R4 irq released after read", irq_n, 1);
        read_reg(8'hC0, v);
        check(v === 8'h20, "R4 transit during read kept", v, 8'h20);
        read_reg(8'hC0, v);
        check(v === 8'h00, "R4 flags cleared", v, 0);
    endtask

    task automatic t_motion;
        logic [39:0] r;
        spi_xfer(4, {8'hC8, 32'h0}, r);
        check(r[31:24] === 8'h09, "R8 report byte1 with click", r[31:24], 8'h09);
        check(r[23:16] === 8'h01, "R8 report X", r[23:16], 8'h01);
        check(r[15:8] === 8'h00, "R8 report Y", r[15:8], 8'h00);
        pulse_motion(8'h05, 8'hFD);
        pulse_motion(8'h02, 8'hFC);
        spi_xfer(5, {8'hC8, 32'h0}, r);
        check(r[31:24] === 8'h28, "R8 report byte1 Y sign", r[31:24], 8'h28);
        check(r[23:16] === 8'h07, "R8 X sum", r[23:16], 8'h07);
        check(r[15:8] === 8'hF9, "R8 Y sum negative", r[15:8], 8'hF9);
        check(r[7:0] === 8'h00, "R8 extra byte zero", r[7:0], 0);
        spi_xfer(4, {8'hC8, 32'h0}, r);
        check(r[31:8] === 24'h080000, "R8 report cleared after read", r[31:8], 24'h080000);
    endtask

    task automatic t_sat;
        logic [39:0] r;
        pulse_motion(8'd100, 8'h9C);
        pulse_motion(8'd100, 8'h9C);
        spi_xfer(4, {8'hC8, 32'h0}, r);
        check(r[31:24] === 8'hE8, "R9 overflow bits", r[31:24], 8'hE8);
        check(r[23:16] === 8'h7F, "R9 X saturates high", r[23:16], 8'h7F);
        check(r[15:8] === 8'h80, "R9 Y saturates low", r[15:8], 8'h80);
    endtask

    task automatic t_unmapped;
        logic [39:0] r;
        logic [7:0] v;
        read_reg(8'hC0, v);
        write_reg(8'h80, 8'hFF);
        read_reg(8'hC0, v);
        check(v === 8'h00, "R10 flag write ignored", v, 0);
        write_reg(8'h88, 8'h55);
        spi_xfer(4, {8'hC8, 32'h0}, r);
        check(r[31:8] === 24'h080000, "R10 report write ignored", r[31:8], 24'h080000);
        write_reg(8'h81, 8'hFF);
        check(cfg_mode === 7'h30 && cfg_irq_en === 5'h08, "R10 unmapped write ignored",
              {cfg_mode, cfg_irq_en}, {7'h30, 5'h08});
        read_reg(8'hC1, v);
        check(v === 8'h00, "R10 unmapped read zero", v, 0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset;
        t_mode;
        t_enable;
        t_abort;
        t_noncmd;
        t_irq;
        t_motion;
        t_sat;
        t_unmapped;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule